// File: doc/BRIEF.md
# Serial ADC Frame Readout Controller

This block sits on the host side of a three-wire serial sampling converter. It divides the system clock down to a serial clock. It opens each conversion frame with a convert pulse that lasts one serial-clock period. It shifts the returned data in, MSB first, on the falling serial-clock edges, and it presents the finished word as a zero-extended 16-bit sample with a one-cycle strobe. Two mode pins are latched at the start of each frame. One chooses a frame of 16 or 18 serial clocks, where the two extra clocks give the converter acquisition time. The other chooses a 14-bit or a 12-bit word.

Conversions begin on a trigger pulse, or run back to back while the continuous level is held high. The converter returns each result one frame late, so the controller also raises a trust flag with every strobe. The first word after reset or after a wake is marked untrusted. After a wake from deep sleep, words stay untrusted until a settle interval has run out. The controller can send the converter into light or deep power-down by issuing two or four convert pulses with the serial clock parked low. It can wake the converter with a single serial-clock pulse while convert stays low.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, `adc_sck`, `adc_conv`, `sample`, `sample_valid` and `sample_trusted` are all zero.
- R2: During a frame, `adc_sck` has a period of `SCK_DIV` system clocks: low for the first half and high for the second. It stays low whenever no frame, power command or wake pulse is in progress.
- R3: Each frame starts with one `adc_conv` rise. `adc_conv` stays high for exactly one serial-clock period and falls half a period before the second `adc_sck` rise. A frame contains 16 `adc_sck` rises when `long_frame`=0 and 18 when `long_frame`=1.
- R4: With `wide_mode`=1, the bits present on `adc_sdo` after rises 3 through 16 are sampled on the following falling edges, MSB first. They form `sample[13:0]`, and `sample[15:14]` is 0.
- R5: With `wide_mode`=0, the bits after rises 3 through 14 form `sample[11:0]`, MSB first. The two bits after rises 15 and 16 are discarded, and `sample[15:12]` is 0.
- R6: `sample_valid` is high for exactly one system clock per frame, on the falling `adc_sck` edge that follows the 16th rise.
- R7: A `trigger` pulse while idle starts exactly one frame. A `trigger` during a frame has no effect. While `continuous`=1, frames follow each other with no gap, and each frame yields one strobe.
- R8: `sample_trusted` is high only together with `sample_valid`. It is 0 for the first word after reset and for the first word after any wake.
- R9: A `pwr_req` pulse while idle issues convert pulses, each high and then low for `SCK_DIV` system clocks, with `adc_sck` held low throughout. It issues 2 pulses (light power-down) when `pwr_sleep`=0 and 4 pulses (deep power-down) when `pwr_sleep`=1.
- R10: While powered down, `trigger` and `continuous` have no effect. A `wake_req` pulse produces exactly one `adc_sck` rise, with `adc_conv` low, and returns the controller to idle.
- R11: After a wake from deep power-down, words completed within `SETTLE_CYC` system clocks of the wake pulse are untrusted, and later words are trusted again. A wake from light power-down imposes no settle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigger | input | 1 | Start one frame when idle |
| continuous | input | 1 | Run frames back to back while high |
| long_frame | input | 1 | 1: 18-clock frame, 0: 16-clock frame |
| wide_mode | input | 1 | 1: 14-bit word, 0: 12-bit word |
| pwr_req | input | 1 | Issue a power-down command when idle |
| pwr_sleep | input | 1 | Power-down depth: 1 deep, 0 light |
| wake_req | input | 1 | Wake the converter from power-down |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_conv | output | 1 | Convert start to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| sample | output | 16 | Received word, zero-extended |
| sample_valid | output | 1 | One-cycle strobe per completed frame |
| sample_trusted | output | 1 | Word is a settled, non-stale result |

## Verification
Most internal faults in this block surface within one frame. A wrong period or bit counter shifts the window in which bits are taken. That shows up as a corrupted `sample` at the very next strobe, or as a wrong number of `adc_sck` rises between `adc_conv` rises. A lost power-down or wake state shows as extra or missing convert pulses, or as serial-clock activity while the converter should be sleeping. It is visible within a few serial periods of the request. A stuck trust or settle state only shows at the first strobe after a reset or wake, or once the settle window has closed. Those strobes are therefore checked directly, on both sides of the window.

// File: rtl/serial_adc_reader.sv
`timescale 1ns/1ps
module serial_adc_reader #(
  parameter int SCK_DIV    = 4,
  parameter int SETTLE_CYC = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trigger,
  input  logic        continuous,
  input  logic        long_frame,
  input  logic        wide_mode,
  input  logic        pwr_req,
  input  logic        pwr_sleep,
  input  logic        wake_req,
  output logic        adc_sck,
  output logic        adc_conv,
  input  logic        adc_sdo,
  output logic [15:0] sample,
  output logic        sample_valid,
  output logic        sample_trusted
);

  localparam int HALF = SCK_DIV / 2;
  localparam int DW   = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam int SW   = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_PWR, S_DOWN, S_WAKE} st_t;

  st_t           st;
  logic [DW-1:0] div;
  logic [4:0]    per;
  logic [4:0]    per_n;
  logic [13:0]   shreg;
  logic [13:0]   shifted;
  logic [2:0]    pcnt;
  logic [SW-1:0] settle_cnt;
  logic          sck_r, conv_r;
  logic          frm_long, frm_wide;
  logic          down_sleep, primed;
  logic          run, fall_ev, rise_ev;

  assign run      = (st == S_FRAME) || (st == S_PWR) || (st == S_WAKE);
  assign fall_ev  = run && (div == '0);
  assign rise_ev  = run && (div == DW'(HALF));
  assign per_n    = per + 5'd1;
  assign shifted  = {shreg[12:0], adc_sdo};
  assign adc_sck  = sck_r;
  assign adc_conv = conv_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      div            <= '0;
      per            <= '0;
      shreg          <= '0;
      pcnt           <= '0;
      settle_cnt     <= '0;
      sck_r          <= 1'b0;
      conv_r         <= 1'b0;
      frm_long       <= 1'b0;
      frm_wide       <= 1'b0;
      down_sleep     <= 1'b0;
      primed         <= 1'b0;
      sample         <= '0;
      sample_valid   <= 1'b0;
      sample_trusted <= 1'b0;
    end else begin
      sample_valid   <= 1'b0;
      sample_trusted <= 1'b0;
      if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
      if (run) div <= (div == DW'(SCK_DIV - 1)) ? '0 : div + 1'b1;

      unique case (st)
        S_IDLE: begin
          if (pwr_req) begin
            st         <= S_PWR;
            div        <= DW'(1);
            conv_r     <= 1'b1;
            pcnt       <= pwr_sleep ? 3'd3 : 3'd1;
            down_sleep <= pwr_sleep;
          end else if (trigger || continuous) begin
            st       <= S_FRAME;
            div      <= DW'(1);
            per      <= '0;
            conv_r   <= 1'b1;
            sck_r    <= 1'b0;
            frm_long <= long_frame;
            frm_wide <= wide_mode;
          end
        end

        S_FRAME: begin
          if (rise_ev) sck_r <= 1'b1;
          if (fall_ev) begin
            sck_r <= 1'b0;
            if (per_n == 5'd1) conv_r <= 1'b0;
            if (per_n >= 5'd3 && per_n <= 5'd16) shreg <= shifted;
            if (per_n == 5'd16) begin
              sample         <= frm_wide ? {2'b00, shifted} : {4'b0000, shifted[13:2]};
              sample_valid   <= 1'b1;
              sample_trusted <= primed && (settle_cnt == '0);
              primed         <= 1'b1;
            end
            if (per_n == (frm_long ? 5'd18 : 5'd16)) begin
              if (continuous) begin
                per      <= '0;
                conv_r   <= 1'b1;
                frm_long <= long_frame;
                frm_wide <= wide_mode;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              per <= per_n;
            end
          end
        end

        S_PWR: begin
          if (fall_ev) begin
            if (conv_r) begin
              conv_r <= 1'b0;
            end else if (pcnt != '0) begin
              conv_r <= 1'b1;
              pcnt   <= pcnt - 1'b1;
            end else begin
              st <= S_DOWN;
            end
          end
        end

        S_DOWN: begin
          if (wake_req) begin
            st  <= S_WAKE;
            div <= DW'(1);
          end
        end

        S_WAKE: begin
          if (rise_ev) sck_r <= 1'b1;
          if (fall_ev) begin
            sck_r  <= 1'b0;
            st     <= S_IDLE;
            primed <= 1'b0;
            if (down_sleep) settle_cnt <= SW'(SETTLE_CYC);
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_DOWN) |-> !adc_sck);

  assert_conv_rise_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> ((st == S_FRAME && per == 5'd0) || st == S_PWR));

  assert_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (sample[15:14] == 2'b00 && (frm_wide || sample[13:12] == 2'b00)));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_trust_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_trusted |-> sample_valid);

  assert_pwr_sck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PWR |-> !adc_sck);

  assert_wake_conv_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAKE |-> !adc_conv);

endmodule

// File: tb/sim_serial_adc_reader.sv
`timescale 1ns/1ps
module sim_serial_adc_reader;
  localparam int SCK_DIV = 4;
  localparam int HALF    = SCK_DIV / 2;
  localparam int SETTLE  = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trigger = 0, continuous = 0, long_frame = 0, wide_mode = 1;
  logic pwr_req = 0, pwr_sleep = 0, wake_req = 0;
  logic adc_sck, adc_conv, adc_sdo = 0;
  logic [15:0] sample;
  logic sample_valid, sample_trusted;

  serial_adc_reader #(.SCK_DIV(SCK_DIV), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .continuous(continuous),
    .long_frame(long_frame), .wide_mode(wide_mode), .pwr_req(pwr_req),
    .pwr_sleep(pwr_sleep), .wake_req(wake_req), .adc_sck(adc_sck),
    .adc_conv(adc_conv), .adc_sdo(adc_sdo), .sample(sample),
    .sample_valid(sample_valid), .sample_trusted(sample_trusted));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model
  logic [13:0] cur_word, out_word;
  int rcnt = 0, consec = 0, conv_rises = 0, sck_rises = 0, exp_len = 16;
  bit pmode = 0, have_prev = 0;
  realtime t_conv_r, t_conv_f, t_r1;
  int exp_q[$];

  always @(posedge adc_conv) begin
    conv_rises++;
    consec++;
    out_word = cur_word;
    cur_word = 14'($urandom);
    if (!pmode) begin
      if (have_prev) chk(rcnt == exp_len, "R3 rises per frame", rcnt, exp_len);
      exp_q.push_back(wide_mode ? int'(out_word) : int'(out_word[11:0]));
      have_prev = 1;
      exp_len = long_frame ? 18 : 16;
    end
    rcnt = 0;
    t_conv_r = $realtime;
  end

  always @(negedge adc_conv) begin
    t_conv_f = $realtime;
    if (!pmode) chk(int'((t_conv_f - t_conv_r) / 8.0) == SCK_DIV, "R3 conv width",
                    int'((t_conv_f - t_conv_r) / 8.0), SCK_DIV);
  end

  always @(posedge adc_sck) begin
    sck_rises++;
    consec = 0;
    rcnt++;
    if (rcnt == 1) t_r1 = $realtime;
    if (rcnt == 2 && !pmode) begin
      chk(int'(($realtime - t_r1) / 8.0) == SCK_DIV, "R2 sck period",
          int'(($realtime - t_r1) / 8.0), SCK_DIV);
      chk(int'(($realtime - t_conv_f) / 8.0) == HALF, "R3 conv fall to rise",
          int'(($realtime - t_conv_f) / 8.0), HALF);
    end
    if (rcnt >= 3 && rcnt <= 16) begin
      if (wide_mode) adc_sdo = out_word[13 - (rcnt - 3)];
      else if (rcnt <= 14) adc_sdo = out_word[11 - (rcnt - 3)];
      else adc_sdo = 1'($urandom);
    end else adc_sdo = 1'($urandom);
  end

  // output monitor
  int vcount = 0;
  bit prev_valid = 0, tb_primed = 0, slept = 0;
  realtime wake_t = 0;

  function automatic int exp_trust();
    int el;
    if (!tb_primed) return 0;
    if (!slept) return 1;
    el = int'(($realtime - wake_t) / 8.0);
    if (el < SETTLE - 4) return 0;
    if (el < SETTLE + SCK_DIV + 8) return 2;
    return 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_valid && prev_valid) chk(0, "R6 strobe width", 2, 1);
      if (sample_trusted && !sample_valid) chk(0, "R8 trust without strobe", 1, 0);
      if (sample_valid) begin
        int e, t;
        vcount++;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
        chk(int'(sample) == e, wide_mode ? "R4 wide word" : "R5 narrow word", int'(sample), e);
        t = exp_trust();
        if (t != 2) chk(int'(sample_trusted) == t, slept ? "R11 settle trust" : "R8 first word trust",
                        int'(sample_trusted), t);
        tb_primed = 1;
      end
      prev_valid = sample_valid;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic wait_idle();
    repeat (24 * SCK_DIV) @(negedge clk);
    chk(rcnt == exp_len, "R3 last frame rises", rcnt, exp_len);
    have_prev = 0;
  endtask

  task automatic run_frames(int n, bit lg, bit wd, bit cont);
    int c0, v0;
    @(negedge clk);
    long_frame = lg; wide_mode = wd;
    c0 = conv_rises; v0 = vcount;
    if (cont) begin
      continuous = 1;
      while (vcount - v0 < n) @(negedge clk);
      continuous = 0;
      wait_idle();
      chk(vcount - v0 == conv_rises - c0, "R7 one strobe per frame", vcount - v0, conv_rises - c0);
      chk(vcount - v0 >= n, "R7 continuous count", vcount - v0, n);
    end else begin
      for (int i = 0; i < n; i++) begin
        pulse(trigger);
        if (i == 0) begin
          repeat (5 * SCK_DIV) @(negedge clk);
          pulse(trigger);
        end
        wait_idle();
      end
      chk(conv_rises - c0 == n, "R7 single frames started", conv_rises - c0, n);
      chk(vcount - v0 == n, "R7 single frame strobes", vcount - v0, n);
    end
  endtask

  task automatic power_down(bit slp);
    int s0, c0;
    pmode = 1; have_prev = 0; consec = 0;
    s0 = sck_rises;
    @(negedge clk) begin pwr_req = 1; pwr_sleep = slp; end
    @(negedge clk) pwr_req = 0;
    repeat (12 * SCK_DIV) @(negedge clk);
    chk(consec == (slp ? 4 : 2), "R9 power-down pulse count", consec, slp ? 4 : 2);
    chk(sck_rises == s0, "R9 sck parked", sck_rises - s0, 0);
    exp_q.delete();
    s0 = sck_rises; c0 = conv_rises;
    pulse(trigger);
    continuous = 1;
    repeat (10 * SCK_DIV) @(negedge clk);
    continuous = 0;
    chk(sck_rises == s0 && conv_rises == c0, "R10 ignored while down",
        (sck_rises - s0) + (conv_rises - c0), 0);
  endtask

  task automatic wake(bit slp);
    int s0, c0;
    s0 = sck_rises; c0 = conv_rises;
    pulse(wake_req);
    wake_t = $realtime;
    repeat (4 * SCK_DIV) @(negedge clk);
    chk(sck_rises - s0 == 1, "R10 wake sck rises", sck_rises - s0, 1);
    chk(conv_rises == c0, "R10 wake conv quiet", conv_rises - c0, 0);
    tb_primed = 0; slept = slp; pmode = 0; rcnt = 0; exp_len = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    cur_word = 14'($urandom);
    repeat (3) @(negedge clk);
    chk(!adc_sck && !adc_conv && !sample_valid && !sample_trusted && sample == 0,
        "R1 reset state", int'(sample), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!adc_sck && !adc_conv, "R2 idle sck low", int'(adc_sck), 0);

    run_frames(1, 0, 1, 0);
    run_frames(2, 0, 0, 0);
    run_frames(1, 1, 1, 0);
    run_frames(3, 0, 1, 1);
    run_frames(3, 1, 0, 1);
    run_frames(2, 0, 0, 1);

    power_down(0);
    wake(0);
    run_frames(2, 0, 1, 0);

    power_down(1);
    wake(1);
    run_frames(3, 0, 1, 1);
    repeat (SETTLE) @(negedge clk);
    run_frames(2, 1, 0, 0);

    for (int r = 0; r < 12; r++) begin
      run_frames(1 + int'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule